// File: doc/BRIEF.md
# Byte-Addressed Quadrature Counter Channel

This block is one channel of a 24-bit up/down position counter that a host reaches through an 8-bit bus with only two locations. One location carries data bytes. The other takes command bytes on a write and returns a status byte on a read. The wide registers are never mapped whole. A shared byte pointer walks through them one byte per data access, least significant byte first. The pointer is used for the preset register on writes and for the output latch on reads.

The counter takes its input from two encoder pins. It can decode them as a clock/direction pair or as a two-phase quadrature signal at one, two or four counts per encoder cycle. Both pins pass through a synchronizer and are then sampled at a rate set by a programmable filter-clock prescaler. The host cannot write the counter directly. It loads a value by filling the preset register and then issuing a transfer command. It reads the count by first freezing it into the output latch with a command and then reading the latch bytes.

Top module: `qc_chan`

## Requirements
- R1: After reset, a status read returns 0x00 and a latched count reads back as zero.
- R2: Command 0x09 resets the byte pointer and copies the counter into the output latch. The next three data reads return the latched value, least significant byte first.
- R3: Data writes fill the preset register byte by byte, and by themselves leave the counter unchanged. Command 0x10 copies the whole preset into the counter.
- R4: Each data access advances the byte pointer by one. After the third byte the pointer returns to byte 0, so a fourth read repeats the least significant byte. Command bit 0 (as in 0x01) resets the pointer.
- R5: In clock/direction mode (mode byte 0x20), a rising edge on encoder A counts up when B is high and down when B is low. Status bit 5 shows the direction of the last count: 1 for up, 0 for down.
- R6: Mode bytes 0x28, 0x30 and 0x38 select quadrature decoding at one, two and four counts per encoder cycle. The sequence A,B = 00,10,11,01 counts up, and the reverse sequence counts down.
- R7: The count wraps modulo 2^24. A wrap up to 0 toggles status bit 1 and clears status bit 3. A wrap down to 0xFFFFFF toggles status bit 0 and sets status bit 3.
- R8: Command 0x02 clears status bits 0 through 3 and leaves the error bit alone. Command 0x04 clears only status bit 4.
- R9: In a quadrature mode, a sample in which A and B both change sets status bit 4 and does not count.
- R10: The I/O control byte 0x40 disables the encoder inputs, and the counter then holds its value. The byte 0x41 enables them.
- R11: Command 0x18 loads the prescaler P from the last data byte written at pointer 0. The inputs are then sampled once every P+1 clocks. With P=7, eight one-clock pulses spaced nine clocks apart give exactly one count. With P=0, the same pulses give eight counts.
- R12: Status bit 2 sets when a count step lands on the preset value. It stays set until command 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one clock per access |
| bus_rd | input | 1 | Host read strobe, one clock per access |
| bus_addr | input | 1 | 0 selects the data location, 1 selects command/status |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Registered read byte, valid the clock after bus_rd |
| enc_a | input | 1 | Encoder A, or the count clock in clock/direction mode |
| enc_b | input | 1 | Encoder B, or the direction in clock/direction mode |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same clock. They also assume that a command and a data access never coincide, since the bus has one address line. The stimulus issues exactly one single-clock access at a time. The quadrature checks, apart from the deliberate illegal-jump test, assume that the encoder pins change one at a time and that each level is held for several sample periods. The bench keeps every encoder level for six clocks while the prescaler is zero. It changes both pins together only in the cases that exercise the error bit.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int BYTE_W = 8;

  // command byte target select, bits [7:5]
  typedef enum logic [2:0] {
    SEL_RLD = 3'd0,
    SEL_CMR = 3'd1,
    SEL_IOR = 3'd2,
    SEL_IDX = 3'd3
  } ctl_sel_e;

  // transfer field of a reload command, bits [4:3]
  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_LATCH = 2'd1,
    XF_LOAD  = 2'd2,
    XF_PSC   = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    SC_CLKDIR = 2'd0,
    SC_X1     = 2'd1,
    SC_X2     = 2'd2,
    SC_X4     = 2'd3
  } scale_e;

  // status byte bits [5:0], MSB first
  typedef struct packed {
    logic up;
    logic err;
    logic sign;
    logic cmp;
    logic carry;
    logic borrow;
  } status_t;
endpackage

// File: rtl/qc_input_filter.sv
module qc_input_filter #(
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_in,
  input  logic             b_in,
  input  logic [PSC_W-1:0] psc,
  input  logic             psc_load,
  output logic [1:0]       ab_prv,
  output logic [1:0]       ab_cur,
  output logic             sample
);
  logic [SYNC_STAGES-1:0] sa_q, sb_q;
  logic [PSC_W-1:0]       div_q;
  logic                   tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_q <= '0;
      sb_q <= '0;
    end else begin
      sa_q <= {sa_q[SYNC_STAGES-2:0], a_in};
      sb_q <= {sb_q[SYNC_STAGES-2:0], b_in};
    end
  end

  assign tick = (div_q == psc);

  always_ff @(posedge clk) begin
    if (rst || psc_load) div_q <= '0;
    else if (tick)       div_q <= '0;
    else                 div_q <= div_q + PSC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_prv <= 2'b00;
      ab_cur <= 2'b00;
      sample <= 1'b0;
    end else begin
      sample <= tick;
      if (tick) begin
        ab_prv <= ab_cur;
        ab_cur <= {sa_q[SYNC_STAGES-1], sb_q[SYNC_STAGES-1]};
      end
    end
  end
endmodule

// File: rtl/qc_step_decode.sv
module qc_step_decode (
  input  qc_pkg::scale_e scale,
  input  logic [1:0]     ab_prv,
  input  logic [1:0]     ab_cur,
  output logic           step,
  output logic           up,
  output logic           illegal
);
  import qc_pkg::*;
  logic [1:0] chg;
  logic       both, a_rise, qdir;

  always_comb begin
    chg     = ab_prv ^ ab_cur;
    both    = &chg;
    a_rise  = ~ab_prv[1] & ab_cur[1];
    qdir    = ab_cur[1] ^ ab_prv[0];
    illegal = (scale != SC_CLKDIR) & both;
    step    = 1'b0;
    up      = qdir;
    unique case (scale)
      SC_CLKDIR: begin step = a_rise;           up = ab_cur[0]; end
      SC_X1:     step = a_rise & ~both;
      SC_X2:     step = chg[1] & ~both;
      SC_X4:     step = (|chg) & ~both;
      default:   step = 1'b0;
    endcase
  end
endmodule

// File: rtl/qc_count_core.sv
module qc_count_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_v,
  input  logic             up,
  input  logic             illegal_v,
  input  logic             load,
  input  logic             clr_flags,
  input  logic             clr_err,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output qc_pkg::status_t  st
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic             adv, wrap_hi, wrap_lo;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    adv     = step_v & ~load;
    nxt     = up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
    wrap_hi = adv & up & (cnt == TOP);
    wrap_lo = adv & ~up & (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      st  <= '0;
    end else begin
      if (load)     cnt <= load_val;
      else if (adv) cnt <= nxt;
      if (adv) st.up <= up;
      if (clr_flags) begin
        st.borrow <= 1'b0;
        st.carry  <= 1'b0;
        st.cmp    <= 1'b0;
        st.sign   <= 1'b0;
      end else begin
        if (wrap_lo) begin
          st.borrow <= ~st.borrow;
          st.sign   <= 1'b1;
        end
        if (wrap_hi) begin
          st.carry <= ~st.carry;
          st.sign  <= 1'b0;
        end
        if (adv && nxt == cmp_val) st.cmp <= 1'b1;
      end
      if (clr_err)        st.err <= 1'b0;
      else if (illegal_v) st.err <= 1'b1;
    end
  end
endmodule

// File: rtl/qc_chan.sv
module qc_chan #(
  parameter int CNT_BYTES   = 3,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       enc_a,
  input  logic       enc_b
);
  import qc_pkg::*;
  localparam int CNT_W  = CNT_BYTES * BYTE_W;
  localparam int NBYTES = CNT_BYTES;
  localparam int BP_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BP_W-1:0] BP_LAST = BP_W'(NBYTES - 1);

  logic [NBYTES-1:0][BYTE_W-1:0] preset_q, latch_q;
  logic [BP_W-1:0]  bp_q;
  logic [PSC_W-1:0] psc_q;
  scale_e           scale_q;
  logic             ab_en_q;
  logic [7:0]       rdata_q;

  ctl_sel_e sel;
  xfer_e    xf;
  logic wr_data, rd_data, wr_ctl, rd_ctl, is_rld;
  logic cmd_bp_rst, cmd_clr_flags, cmd_clr_err, cmd_latch, cmd_load, cmd_psc;

  logic [1:0]       ab_prv, ab_cur;
  logic             sample, step, up, illegal;
  logic [CNT_W-1:0] cnt_w;
  status_t          status_w;

  always_comb begin
    sel           = ctl_sel_e'(bus_wdata[7:5]);
    xf            = xfer_e'(bus_wdata[4:3]);
    wr_data       = bus_wr & ~bus_addr;
    rd_data       = bus_rd & ~bus_addr;
    wr_ctl        = bus_wr & bus_addr;
    rd_ctl        = bus_rd & bus_addr;
    is_rld        = wr_ctl & (sel == SEL_RLD);
    cmd_bp_rst    = is_rld & bus_wdata[0];
    cmd_clr_flags = is_rld & bus_wdata[1];
    cmd_clr_err   = is_rld & bus_wdata[2];
    cmd_latch     = is_rld & (xf == XF_LATCH);
    cmd_load      = is_rld & (xf == XF_LOAD);
    cmd_psc       = is_rld & (xf == XF_PSC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q <= '0;
    end else if (cmd_bp_rst) begin
      bp_q <= '0;
    end else if (wr_data || rd_data) begin
      bp_q <= (bp_q == BP_LAST) ? '0 : bp_q + BP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= '0;
      latch_q  <= '0;
      psc_q    <= '0;
      scale_q  <= SC_CLKDIR;
      ab_en_q  <= 1'b0;
    end else begin
      if (wr_data)   preset_q[bp_q] <= bus_wdata;
      if (cmd_latch) latch_q <= cnt_w;
      if (cmd_psc)   psc_q <= preset_q[0][PSC_W-1:0];
      if (wr_ctl && sel == SEL_CMR) scale_q <= scale_e'(bus_wdata[4:3]);
      if (wr_ctl && sel == SEL_IOR) ab_en_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_data) rdata_q <= latch_q[bp_q];
    else if (rd_ctl)  rdata_q <= {2'b00, status_w};
  end
  assign bus_rdata = rdata_q;

  qc_input_filter #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) filt_i (
    .clk(clk), .rst(rst), .a_in(enc_a), .b_in(enc_b),
    .psc(psc_q), .psc_load(cmd_psc),
    .ab_prv(ab_prv), .ab_cur(ab_cur), .sample(sample)
  );

  qc_step_decode dec_i (
    .scale(scale_q), .ab_prv(ab_prv), .ab_cur(ab_cur),
    .step(step), .up(up), .illegal(illegal)
  );

  qc_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst),
    .step_v(sample & step & ab_en_q), .up(up),
    .illegal_v(sample & illegal & ab_en_q),
    .load(cmd_load), .clr_flags(cmd_clr_flags), .clr_err(cmd_clr_err),
    .load_val(preset_q), .cmp_val(preset_q),
    .cnt(cnt_w), .st(status_w)
  );
endmodule

// File: rtl/qc_chan_chk.sv
module qc_chan_chk #(
  parameter int CNT_W  = 24,
  parameter int NBYTES = 3,
  parameter int BP_W   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset,
  input logic [BP_W-1:0]  bp,
  input logic [5:0]       status,
  input logic             ab_en
);
  logic rld_wr, xfer_wr, clrf_wr, clre_wr, bprst_wr, data_acc;
  assign rld_wr   = bus_wr && bus_addr && (bus_wdata[7:5] == 3'b000);
  assign xfer_wr  = rld_wr && (bus_wdata[4:3] == 2'b10);
  assign clrf_wr  = rld_wr && bus_wdata[1];
  assign clre_wr  = rld_wr && bus_wdata[2];
  assign bprst_wr = rld_wr && bus_wdata[0];
  assign data_acc = (bus_wr || bus_rd) && !bus_addr;

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0 && bp == '0 && status == 6'd0)); // R1

  AST_BP_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(bp) < NBYTES); // R4

  AST_BP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !bprst_wr) |=>
      int'(bp) == ((int'($past(bp)) == NBYTES - 1) ? 0 : int'($past(bp)) + 1)); // R4

  AST_PRESET_XFER: assert property (@(posedge clk) disable iff (rst)
    xfer_wr |=> cnt == $past(preset)); // R3

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_en && !xfer_wr) |=> $stable(cnt)); // R10

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    clrf_wr |=> status[3:0] == 4'd0); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[4] && !clre_wr) |=> status[4]); // R8

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clre_wr |=> !status[4]); // R8
endmodule

bind qc_chan qc_chan_chk #(.CNT_W(CNT_W), .NBYTES(NBYTES), .BP_W(BP_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_w), .preset(preset_q), .bp(bp_q),
  .status(status_w), .ab_en(ab_en_q)
);

// File: tb/qc_chan_tb_top.sv
`timescale 1ns/1ps
module qc_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       enc_a = 1'b0, enc_b = 1'b0;
  int         checks = 0, errors = 0;
  int         ph = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  qc_chan dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic adr, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = adr; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic adr, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = adr;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic read_cnt(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    wr(1'b1, 8'h09);
    rd(1'b0, b0); rd(1'b0, b1); rd(1'b0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic write_preset(input logic [23:0] v);
    wr(1'b1, 8'h01);
    wr(1'b0, v[7:0]); wr(1'b0, v[15:8]); wr(1'b0, v[23:16]);
  endtask

  task automatic load_cnt(input logic [23:0] v);
    write_preset(v);
    wr(1'b1, 8'h10);
  endtask

  task automatic status(output logic [7:0] s);
    rd(1'b1, s);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input logic dir_up);
    set_ab(1'b1, dir_up);
    set_ab(1'b0, dir_up);
  endtask

  function automatic logic [1:0] ab_of(input int p);
    case (p)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic qstep(input logic fwd);
    ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
    set_ab(ab_of(ph)[1], ab_of(ph)[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  s, b;
    logic [23:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    status(s);   check("R1 status", 32'(s), 32'h00);
    read_cnt(v); check("R1 count", 32'(v), 32'h0);

    wr(1'b1, 8'h41);  // R10 enable inputs
    wr(1'b1, 8'h20);  // clock/direction mode

    // R3 preset bytes do not touch the counter until transfer
    write_preset(24'h123456);
    read_cnt(v); check("R3 before transfer", 32'(v), 32'h0);
    wr(1'b1, 8'h10);
    read_cnt(v); check("R3 after transfer", 32'(v), 32'h123456);

    // R2 / R4 byte order and pointer wrap
    wr(1'b1, 8'h09);
    rd(1'b0, b); check("R2 byte0", 32'(b), 32'h56);
    rd(1'b0, b); check("R2 byte1", 32'(b), 32'h34);
    rd(1'b0, b); check("R2 byte2", 32'(b), 32'h12);
    rd(1'b0, b); check("R4 wrap to byte0", 32'(b), 32'h56);
    wr(1'b1, 8'h01);
    rd(1'b0, b); check("R4 pointer reset", 32'(b), 32'h56);

    // R5 clock/direction
    for (int i = 0; i < 5; i++) pulse(1'b1);
    status(s); check("R5 up flag", 32'(s[5]), 32'h1);
    for (int i = 0; i < 2; i++) pulse(1'b0);
    status(s); check("R5 down flag", 32'(s[5]), 32'h0);
    read_cnt(v); check("R5 count", 32'(v), 32'h123459);

    // R12 compare on landing at preset
    status(s); check("R12 cmp clear before", 32'(s[2]), 32'h0);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    read_cnt(v); check("R12 count", 32'(v), 32'h123456);
    status(s); check("R12 cmp set", 32'(s[2]), 32'h1);
    wr(1'b1, 8'h02);
    status(s); check("R8 flags cleared", 32'(s[3:0]), 32'h0);

    // R7 wrap behaviour
    load_cnt(24'hFFFFFF);
    wr(1'b1, 8'h02);
    pulse(1'b1);
    read_cnt(v); check("R7 wrap up count", 32'(v), 32'h0);
    status(s);   check("R7 wrap up status", 32'(s), 32'h22);
    pulse(1'b0);
    read_cnt(v); check("R7 wrap down count", 32'(v), 32'hFFFFFF);
    status(s);   check("R7 wrap down status", 32'(s), 32'h0F);
    pulse(1'b1);
    status(s);   check("R7 second carry toggle", 32'(s), 32'h25);

    // R6 quadrature scales
    set_ab(1'b0, 1'b0);
    ph = 0;
    for (int k = 1; k <= 3; k++) begin
      int mult;
      mult = 1 << (k - 1);
      load_cnt(24'd1000);
      wr(1'b1, 8'(8'h20 | (k << 3)));
      for (int i = 0; i < 20; i++) qstep(1'b1);
      read_cnt(v); check($sformatf("R6 x%0d up", mult), 32'(v), 32'(1000 + 5 * mult));
      for (int i = 0; i < 12; i++) qstep(1'b0);
      read_cnt(v); check($sformatf("R6 x%0d down", mult), 32'(v), 32'(1000 + 2 * mult));
    end

    // R9 illegal jump in x4 mode
    set_ab(1'b1, 1'b1);
    status(s);   check("R9 error set", 32'(s[4]), 32'h1);
    read_cnt(v); check("R9 no count", 32'(v), 32'(1000 + 8));
    set_ab(1'b0, 1'b0);
    wr(1'b1, 8'h02);
    status(s); check("R8 error kept by flag clear", 32'(s[4]), 32'h1);
    wr(1'b1, 8'h04);
    status(s); check("R8 error cleared", 32'(s[4]), 32'h0);

    // R10 inputs disabled
    wr(1'b1, 8'h40);
    ph = 0;
    for (int i = 0; i < 8; i++) qstep(1'b1);
    read_cnt(v); check("R10 held", 32'(v), 32'(1000 + 8));
    wr(1'b1, 8'h41);

    // R11 prescaler
    wr(1'b1, 8'h20);
    set_ab(1'b0, 1'b1);
    load_cnt(24'd0);
    wr(1'b1, 8'h01); wr(1'b0, 8'd7); wr(1'b1, 8'h18);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); enc_a = 1'b1;
      @(negedge clk); enc_a = 1'b0;
      repeat (7) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    read_cnt(v); check("R11 P=7 one sample", 32'(v), 32'h1);
    wr(1'b1, 8'h01); wr(1'b0, 8'd0); wr(1'b1, 8'h18);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); enc_a = 1'b1;
      @(negedge clk); enc_a = 1'b0;
      repeat (7) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    read_cnt(v); check("R11 P=0 all samples", 32'(v), 32'h9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule